// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block is the master end of a four-peripheral SPI link. A byte and a 2-bit peripheral index arrive through a valid/ready write port and go into a one-entry holding buffer. From there they are shifted out MSB first in SPI mode 0, and the byte clocked in from MISO is returned on a result port. The sequencer owns the four active-low select lines. Before it asserts a line it waits a settle time set for that peripheral. After every byte it waits a per-peripheral tail time. Each peripheral also has a keep bit. When the bit is set, that peripheral's line stays asserted while the buffer is empty, and the line is released only when a byte for another peripheral shows up. When the bit is clear, the line is released as soon as the last queued byte has finished.

The write port applies back-pressure in a simple way. `wr_ready` is high only when the holding buffer is empty, master operation is enabled and no fault is latched. A byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the source must hold its byte. The result port has no back-pressure: `rd_valid` is a one-cycle pulse and must be consumed in that cycle.

A low level on the shared select sense input while master operation is enabled means another master is driving the bus. The block then latches a fault, releases every line, stops the serial clock and data, and discards any byte waiting in the buffer. It stays in this state until `fault_clr` is pulsed.

Top module: `spi_csq_master`

## Requirements
- R1: After reset, `cs_n` is 4'hF, `sck` and `mosi` are 0, `rd_valid` and `mode_fault` are 0, and `wr_ready` is 1 when `master_en` is 1.
- R2: A byte is sent MSB first in mode 0. `sck` idles low, `mosi` holds its bit while `sck` is high and changes only on a falling edge, and each byte produces 8 `sck` pulses. Each high phase and each low phase lasts `cfg_div` clocks (0 counts as 1).
- R3: The clock cycle after the 8th falling edge of `sck`, `rd_valid` pulses for one cycle and `rd_data` carries the 8 MISO bits sampled on the rising edges, the first sample in bit 7.
- R4: A byte written with `wr_sel` = p drives `cs_n[p]` low, and only that line, for the whole byte. Bit p of `cs_n` belongs to peripheral p.
- R5: If keep bit `cfg_keep[p]` is 0 and no byte is waiting when peripheral p's byte ends, `cs_n` returns to 4'hF no later than two clocks after the last falling edge of `sck`.
- R6: If `cfg_keep[p]` is 1, peripheral p's line stays low indefinitely after its byte while the buffer is empty.
- R7: When the next byte is for the peripheral whose line is still low (because its keep bit is set, or because the byte was already waiting), the line does not go high between the two bytes.
- R8: Between the last falling edge of a byte for peripheral p and the first rising edge of the next byte there are at least `cfg_tail` field p clocks (byte p of the 32-bit vector, bits [8p+7:8p]).
- R9: The block never moves directly from one asserted line to another. All lines are high for at least `cfg_settle` field p clocks (bits [8p+7:8p]) before `cs_n[p]` falls.
- R10: `wr_ready` is 1 exactly when the buffer is empty, `master_en` is 1 and no fault is latched. A buffered byte is kept unchanged until it is started.
- R11: With `master_en` = 1, a low `nss_in` sets `mode_fault` within two clocks. From the next cycle on, `cs_n` is 4'hF, `sck` is low and `wr_ready` is 0. A buffered byte is discarded. `fault_clr` clears the fault and has priority over setting it.
- R12: With `master_en` = 0, `nss_in` is ignored (`mode_fault` stays 0) and `wr_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Enables master operation and fault sensing |
| cfg_div | input | 8 | SCK half-period in clocks (0 treated as 1) |
| cfg_keep | input | 4 | Per-peripheral keep-select bit |
| cfg_tail | input | 32 | Per-peripheral post-byte delay, 8 bits each |
| cfg_settle | input | 32 | Per-peripheral pre-select delay, 8 bits each |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Holding buffer can accept a byte |
| wr_data | input | 8 | Byte to send |
| wr_sel | input | 2 | Target peripheral index |
| rd_valid | output | 1 | One-cycle pulse: received byte on rd_data |
| rd_data | output | 8 | Byte received on MISO |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low peripheral selects |
| nss_in | input | 1 | Shared select sense from the bus |
| fault_clr | input | 1 | Clears the latched mode fault |
| mode_fault | output | 1 | Latched mode-fault flag |

## Verification
Two functions can act in the same clock: the write port taking a new byte, and fault sensing. This happens when the buffer has just emptied into a running transfer. The bench drives a handshake and pulls `nss_in` low at the same edge, so the byte is taken into the buffer and the fault latch starts one edge later. The outcome is judged at the ports. The fault must appear, the lines must go high, `sck` must stop, and after the fault is cleared `wr_ready` must be high with no further `sck` edges. That shows the byte taken in the collision cycle was discarded and never sent.

// File: rtl/spi_csq_pkg.sv
package spi_csq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETTLE,
    SQ_SHIFT,
    SQ_TAIL
  } seq_state_t;
endpackage

// File: rtl/spi_csq_shift.sv
module spi_csq_shift #(
  parameter int DW    = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [DW-1:0]    din,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    dout
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic [DIV_W-1:0] div_eff, dcnt;
  logic [BW-1:0]    bcnt;
  logic [DW-1:0]    tsh, rsh;
  logic             busy_r, sck_r, done_r;
  logic             tick;

  assign div_eff = (div == '0) ? DIV_W'(1) : div;
  assign tick    = (dcnt == div_eff - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      sck_r  <= 1'b0;
      done_r <= 1'b0;
      dcnt   <= '0;
      bcnt   <= '0;
      tsh    <= '0;
      rsh    <= '0;
    end else begin
      done_r <= 1'b0;
      if (abort) begin
        busy_r <= 1'b0;
        sck_r  <= 1'b0;
        dcnt   <= '0;
      end else if (start) begin
        busy_r <= 1'b1;
        sck_r  <= 1'b0;
        dcnt   <= '0;
        bcnt   <= '0;
        tsh    <= din;
      end else if (busy_r) begin
        if (tick) begin
          dcnt <= '0;
          if (!sck_r) begin
            sck_r <= 1'b1;
            rsh   <= {rsh[DW-2:0], miso};
          end else begin
            sck_r <= 1'b0;
            tsh   <= {tsh[DW-2:0], 1'b0};
            if (bcnt == BW'(DW-1)) begin
              busy_r <= 1'b0;
              done_r <= 1'b1;
            end else begin
              bcnt <= bcnt + BW'(1);
            end
          end
        end else begin
          dcnt <= dcnt + DIV_W'(1);
        end
      end
    end
  end

  assign sck  = sck_r;
  assign mosi = busy_r & tsh[DW-1];
  assign busy = busy_r;
  assign done = done_r;
  assign dout = rsh;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_r |-> !sck_r); // R2
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_r && $past(sck_r)) |-> $stable(mosi)); // R2
endmodule

// File: rtl/spi_csq_seq.sv
module spi_csq_seq
  import spi_csq_pkg::*;
#(
  parameter int NCS   = 4,
  parameter int DW    = 8,
  parameter int DLY_W = 8,
  parameter int SW    = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault,
  input  logic               master_en,
  input  logic [NCS-1:0]     keep,
  input  logic [NCS*DLY_W-1:0] tail_cfg,
  input  logic [NCS*DLY_W-1:0] settle_cfg,
  input  logic               wr_valid,
  input  logic [DW-1:0]      wr_data,
  input  logic [SW-1:0]      wr_sel,
  output logic               wr_ready,
  output logic               start,
  output logic [DW-1:0]      word,
  input  logic               done,
  output logic               cs_act,
  output logic [SW-1:0]      cur
);
  seq_state_t       st;
  logic [DLY_W-1:0] cnt;
  logic [DLY_W-1:0] tail_a   [NCS];
  logic [DLY_W-1:0] settle_a [NCS];
  logic             buf_full, act_r;
  logic [DW-1:0]    buf_data;
  logic [SW-1:0]    buf_sel, cur_r;

  for (genvar g = 0; g < NCS; g++) begin : g_cfg
    assign tail_a[g]   = tail_cfg[g*DLY_W +: DLY_W];
    assign settle_a[g] = settle_cfg[g*DLY_W +: DLY_W];
  end

  assign wr_ready = master_en && !fault && !buf_full;

  always_comb begin
    start = 1'b0;
    if (!fault) begin
      if (st == SQ_IDLE && buf_full && act_r && buf_sel == cur_r) start = 1'b1;
      if (st == SQ_SETTLE && cnt == '0) start = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      cnt      <= '0;
      buf_full <= 1'b0;
      buf_data <= '0;
      buf_sel  <= '0;
      cur_r    <= '0;
      act_r    <= 1'b0;
    end else if (fault) begin
      st       <= SQ_IDLE;
      cnt      <= '0;
      buf_full <= 1'b0;
      act_r    <= 1'b0;
    end else begin
      if (wr_valid && wr_ready) begin
        buf_full <= 1'b1;
        buf_data <= wr_data;
        buf_sel  <= wr_sel;
      end else if (start) begin
        buf_full <= 1'b0;
      end
      case (st)
        SQ_IDLE: begin
          if (buf_full) begin
            if (act_r && buf_sel == cur_r) begin
              st <= SQ_SHIFT;
            end else begin
              act_r <= 1'b0;
              cur_r <= buf_sel;
              cnt   <= settle_a[buf_sel];
              st    <= SQ_SETTLE;
            end
          end
        end
        SQ_SETTLE: begin
          if (cnt == '0) begin
            act_r <= 1'b1;
            st    <= SQ_SHIFT;
          end else begin
            cnt <= cnt - DLY_W'(1);
          end
        end
        SQ_SHIFT: begin
          if (done) begin
            if (!keep[cur_r] && !buf_full) act_r <= 1'b0;
            cnt <= tail_a[cur_r];
            st  <= SQ_TAIL;
          end
        end
        default: begin
          if (cnt == '0) st <= SQ_IDLE;
          else cnt <= cnt - DLY_W'(1);
        end
      endcase
    end
  end

  assign word   = buf_data;
  assign cs_act = act_r;
  assign cur    = cur_r;

  AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !start && !fault) |=> (buf_full && $stable(buf_data))); // R10
  AST_SELECT_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_SHIFT && !fault) |-> act_r); // R4
endmodule

// File: rtl/spi_csq_fault.sv
module spi_csq_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  input  logic nss_in,
  input  logic clr,
  output logic fault
);
  logic nss_q, flt_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nss_q <= 1'b1;
      flt_r <= 1'b0;
    end else begin
      nss_q <= nss_in;
      if (clr) flt_r <= 1'b0;
      else if (master_en && !nss_q) flt_r <= 1'b1;
    end
  end

  assign fault = flt_r;

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_r && !clr) |=> flt_r); // R11
  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && !nss_q && !clr) |=> flt_r); // R11
endmodule

// File: rtl/spi_csq_master.sv
module spi_csq_master #(
  parameter int NCS   = 4,
  parameter int DW    = 8,
  parameter int DLY_W = 8,
  parameter int DIV_W = 8,
  localparam int SW   = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               master_en,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [NCS-1:0]     cfg_keep,
  input  logic [NCS*DLY_W-1:0] cfg_tail,
  input  logic [NCS*DLY_W-1:0] cfg_settle,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [DW-1:0]      wr_data,
  input  logic [SW-1:0]      wr_sel,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic [NCS-1:0]     cs_n,
  input  logic               nss_in,
  input  logic               fault_clr,
  output logic               mode_fault
);
  logic          fault, start, done, busy, cs_act;
  logic [DW-1:0] word;
  logic [SW-1:0] cur;

  spi_csq_fault u_fault (
    .clk(clk), .rst_n(rst_n), .master_en(master_en),
    .nss_in(nss_in), .clr(fault_clr), .fault(fault)
  );

  spi_csq_seq #(.NCS(NCS), .DW(DW), .DLY_W(DLY_W), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .fault(fault), .master_en(master_en),
    .keep(cfg_keep), .tail_cfg(cfg_tail), .settle_cfg(cfg_settle),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_sel(wr_sel),
    .wr_ready(wr_ready), .start(start), .word(word), .done(done),
    .cs_act(cs_act), .cur(cur)
  );

  spi_csq_shift #(.DW(DW), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(fault), .din(word),
    .div(cfg_div), .miso(miso), .sck(sck), .mosi(mosi), .busy(busy),
    .done(done), .dout(rd_data)
  );

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_n[g] = !(cs_act && cur == SW'(g));
  end

  assign rd_valid   = done;
  assign mode_fault = fault;

  AST_CS_STEADY_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n || fault)
    (busy && $past(busy)) |-> $stable(cs_n)); // R4
  AST_NO_DIRECT_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1 && $past(cs_n) != '1) |-> cs_n == $past(cs_n)); // R9
  AST_QUIET_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (cs_n == '1 && !sck)); // R11
endmodule

// File: tb/tb_spi_csq_master.sv
module tb_spi_csq_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_en = 1'b1;
  logic [7:0]  cfg_div = 8'd2;
  logic [3:0]  cfg_keep = 4'b1010;
  logic [31:0] cfg_tail = {8'd6, 8'd3, 8'd5, 8'd2};
  logic [31:0] cfg_settle = {8'd9, 8'd4, 8'd7, 8'd3};
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = 8'h00;
  logic [1:0]  wr_sel = 2'd0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        sck, mosi, miso;
  logic [3:0]  cs_n;
  logic        nss_in = 1'b1;
  logic        fault_clr = 1'b0;
  logic        mode_fault;

  always #10 clk = ~clk;

  spi_csq_master dut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .cfg_div(cfg_div),
    .cfg_keep(cfg_keep), .cfg_tail(cfg_tail), .cfg_settle(cfg_settle),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_sel(wr_sel),
    .rd_valid(rd_valid), .rd_data(rd_data), .sck(sck), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .nss_in(nss_in), .fault_clr(fault_clr), .mode_fault(mode_fault)
  );

  // {sel[1:0], data[7:0]}
  localparam logic [9:0] VEC [0:7] = '{10'h0A5, 10'h03C, 10'h181, 10'h17E,
                                       10'h3C3, 10'h25A, 10'h201, 10'h0FF};

  int nchk = 0, nerr = 0;
  int cyc = 0, bitn = 0, nw = 0, nr = 0, rises = 0, hi_ev = 0;
  int last_fall = 0, last_rise = 0, hi_start = 0, cur_gap = 0, hp_bad = 0;
  logic       mon_clr = 1'b0;
  logic       sck_p = 1'b0;
  logic [3:0] cs_p = 4'hF, word_cs = 4'hF;
  logic [7:0] mon = 8'h00;
  logic [7:0] cap [16];
  logic [7:0] rxg [16];
  logic [3:0] csw [16];
  int         gap [16];
  logic [7:0] sb;

  function automatic logic [7:0] slv(input int n);
    return 8'h3C ^ 8'(n * 29);
  endfunction
  function automatic int tail_of(input int p);
    return int'(cfg_tail[p*8 +: 8]);
  endfunction
  function automatic int settle_of(input int p);
    return int'(cfg_settle[p*8 +: 8]);
  endfunction

  always_comb sb = slv(nw);
  assign miso = (bitn < 8) ? sb[3'(7 - bitn)] : 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) bitn = 0;
    if (sck && !sck_p) begin
      rises++;
      if (bitn == 0) begin
        cur_gap = cyc - last_fall;
        word_cs = cs_n;
      end
      mon = {mon[6:0], mosi};
      bitn++;
      last_rise = cyc;
    end
    if (!sck && sck_p) begin
      if (cyc - last_rise != int'(cfg_div)) hp_bad++;
      last_fall = cyc;
      if (bitn == 8) begin
        if (nw < 16) begin
          cap[nw] = mon; gap[nw] = cur_gap; csw[nw] = word_cs;
        end
        nw++;
        bitn = 0;
      end
    end
    if (cs_n == 4'hF && cs_p != 4'hF) begin
      hi_start = cyc;
      hi_ev++;
    end
    if (cs_n != 4'hF && cs_p == 4'hF) begin
      for (int i = 0; i < 4; i++)
        if (!cs_n[i]) chk(cyc - hi_start >= settle_of(i), "R9", "settle gap", cyc - hi_start, settle_of(i));
    end
    if (rd_valid) begin
      if (nr < 16) rxg[nr] = rd_data;
      nr++;
    end
    sck_p = sck;
    cs_p  = cs_n;
  end

  task automatic send(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = s; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    while (nr < n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r0, h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 4'hF, "R1", "cs_n", cs_n, 4'hF);
    chk(!sck, "R1", "sck", sck, 0);
    chk(!mosi, "R1", "mosi", mosi, 0);
    chk(!rd_valid, "R1", "rd_valid", rd_valid, 0);
    chk(!mode_fault, "R1", "mode_fault", mode_fault, 0);
    chk(wr_ready, "R1", "wr_ready", wr_ready, 1);

    // table walk
    for (int i = 0; i < 8; i++) send(VEC[i][9:8], VEC[i][7:0]);
    wait_rx(8);
    repeat (20) @(negedge clk);
    chk(nr == 8, "R3", "rx count", nr, 8);
    for (int i = 0; i < 8; i++) begin
      chk(cap[i] == VEC[i][7:0], "R2", "mosi byte", cap[i], VEC[i][7:0]);
      chk(rxg[i] == slv(i), "R3", "rd_data", rxg[i], slv(i));
      chk(csw[i] == ~(4'b1 << VEC[i][9:8]), "R4", "select", csw[i], ~(4'b1 << VEC[i][9:8]));
      if (i > 0 && VEC[i][9:8] == VEC[i-1][9:8]) begin
        chk(gap[i] >= tail_of(int'(VEC[i-1][9:8])), "R8", "tail min", gap[i], tail_of(int'(VEC[i-1][9:8])));
        chk(gap[i] <= tail_of(int'(VEC[i-1][9:8])) + int'(cfg_div) + 4, "R8", "tail max", gap[i],
            tail_of(int'(VEC[i-1][9:8])) + int'(cfg_div) + 4);
      end
    end
    chk(hp_bad == 0, "R2", "half period errors", hp_bad, 0);

    // R6 keep set holds select while empty
    send(2'd1, 8'h42);
    wait_rx(9);
    repeat (100) @(negedge clk);
    chk(cs_n == 4'b1101, "R6", "held select", cs_n, 4'b1101);

    // R7 same peripheral continues without release
    h = hi_ev;
    send(2'd1, 8'h24);
    wait_rx(10);
    repeat (10) @(negedge clk);
    chk(hi_ev == h, "R7", "release events", hi_ev, h);
    chk(cs_n == 4'b1101, "R7", "select kept", cs_n, 4'b1101);
    chk(cap[9] == 8'h24, "R2", "mosi byte", cap[9], 8'h24);

    // R9 switch peripheral, R5 release with keep clear
    send(2'd0, 8'h99);
    wait_rx(11);
    repeat (3) @(negedge clk);
    chk(cs_n == 4'hF, "R5", "released", cs_n, 4'hF);
    chk(hi_ev == h + 2, "R9", "release before switch", hi_ev, h + 2);
    chk(csw[10] == 4'b1110, "R4", "select", csw[10], 4'b1110);

    // R11 fault colliding with a handshake
    r0 = rises;
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = 2'd2; wr_data = 8'h5A;
    while (rises == r0) @(negedge clk);
    wr_sel = 2'd3; wr_data = 8'h66;
    while (!wr_ready) @(negedge clk);
    nss_in = 1'b0;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(mode_fault, "R11", "fault set", mode_fault, 1);
    chk(cs_n == 4'hF, "R11", "cs released", cs_n, 4'hF);
    chk(!sck, "R11", "sck low", sck, 0);
    chk(!wr_ready, "R11", "wr_ready low", wr_ready, 0);
    r0 = rises;
    repeat (50) @(negedge clk);
    chk(rises == r0, "R11", "sck stopped", rises - r0, 0);
    nss_in = 1'b1;
    @(negedge clk);
    fault_clr = 1'b1; mon_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0; mon_clr = 1'b0;
    repeat (2) @(negedge clk);
    chk(!mode_fault, "R11", "fault cleared", mode_fault, 0);
    chk(wr_ready, "R11", "buffer discarded", wr_ready, 1);
    repeat (100) @(negedge clk);
    chk(rises == r0, "R11", "discarded byte not sent", rises - r0, 0);
    chk(cs_n == 4'hF, "R11", "lines idle", cs_n, 4'hF);

    // R12 master disabled ignores nss_in
    master_en = 1'b0;
    @(negedge clk);
    nss_in = 1'b0;
    repeat (10) @(negedge clk);
    chk(!mode_fault, "R12", "no fault when disabled", mode_fault, 0);
    chk(!wr_ready, "R12", "wr_ready when disabled", wr_ready, 0);
    chk(!wr_ready, "R10", "no accept when disabled", wr_ready, 0);
    nss_in = 1'b1;
    repeat (3) @(negedge clk);
    master_en = 1'b1;
    @(negedge clk);
    chk(wr_ready, "R10", "ready when enabled and empty", wr_ready, 1);

    finish_run();
  end
endmodule